// File: doc/BRIEF.md
# Cascaded Vectored Interrupt Controller

This block gathers interrupt requests from peripheral lines and presents a single interrupt to the processor. Inside it, two identical eight-line priority units are chained. The secondary unit's interrupt output feeds line 2 of the primary unit. That leaves fifteen usable request lines: primary lines 0, 1 and 3 to 7, and secondary lines 8 to 15. A request on the old line 2 input is steered onto secondary line 9, so older peripherals keep working.

Each unit latches a request on its rising edge. It resolves fixed priority among its pending lines and tracks the handlers that are in service, which allows nesting. When the processor pulses its acknowledge, the unit that owns the winning line places an 8-bit vector on the result bus for one cycle. If the winner sits behind the cascade link, the primary hands the acknowledge to the secondary and drives nothing itself. A small write port loads the vector bases and issues end-of-interrupt commands to each unit.

Top module: `pic_cascade_ctrl`

## Requirements
- R1: After reset, `int_out` is low, `vec_valid` is low, nothing is pending and nothing is in service.
- R2: A rising edge on a request line latches a pending request. A line that stays high after its request has been served does not raise a new request; only a fresh low-to-high transition does.
- R3: Priority is fixed. Within a unit, the lowest line index wins. When several edges arrive in the same cycle, the lowest index is served first.
- R4: The vector is the unit's 5-bit base in bits 7..3 and the winning line index (0..7) in bits 2..0. A write to address 0 (primary) or 1 (secondary) loads the base from `reg_wdata[7:3]`, and `reg_wdata[2:0]` is ignored. The vector appears with `vec_valid` high for exactly one cycle, in the cycle after the acknowledge pulse.
- R5: A pending request whose index is lower than every in-service index of its unit raises `int_out`, even while a handler is in service. A pending request of equal or lower priority keeps `int_out` low until the blocking in-service bit is cleared.
- R6: External lines 8..15 are secondary indices 0..7, and all of them rank at the position of primary line 2. A secondary winner's vector comes from the secondary unit with the secondary base. The primary never drives the bus at the same time.
- R7: A request on external line 2 is served as secondary index 1 and returns the secondary base with index 1.
- R8: An end-of-interrupt command clears the highest-priority (lowest index) in-service bit of the addressed unit. Address 2 addresses the primary and address 3 the secondary. A cascaded request needs one command to each unit.
- R9: An acknowledge while `int_out` is low is ignored. No vector is produced and no pending or in-service state changes.
- R10: While any secondary line is in service, another secondary request, even one of higher priority within the secondary, keeps `int_out` low until the primary's line 2 has received its end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 16 | External request lines; bit 2 is redirected to secondary index 1 |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge pulse from the processor |
| reg_wr | input | 1 | Write strobe for the command port |
| reg_addr | input | 2 | 0 primary base, 1 secondary base, 2 primary EOI, 3 secondary EOI |
| reg_wdata | input | 8 | Write data; base in bits 7..3 |
| vec_valid | output | 1 | Vector present on `vec_data` this cycle |
| vec_data | output | 8 | Vector of the acknowledged line |

## Verification
The bench sends edges that arrive together, so that the lowest index must win. A design that scanned priority from the wrong end would return the larger vector first. It interleaves higher-priority edges with handlers that are already in service. A broken nesting rule would then either miss the preemption or let an equal or lower line through, and the bench sees this as `int_out` at the wrong level. Cascaded requests check that the secondary base reaches the bus, that legacy line 2 comes back as secondary index 1, and that one end-of-interrupt alone does not release the chain. A design that dropped a unit's in-service bit too early would raise the interrupt prematurely. The bench also holds a line high across service, to catch a request that is level-sensitive by mistake, and issues an acknowledge while nothing is ready, which must yield no vector.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int UNIT_LINES   = 8;
    localparam int IDX_W        = $clog2(UNIT_LINES);
    localparam int VEC_W        = 8;
    localparam int BASE_W       = VEC_W - IDX_W;
    localparam int EXT_LINES    = 2 * UNIT_LINES;
    localparam int CASCADE_LINE = 2;
    localparam int LEGACY_LINE  = 2;
    localparam int REDIRECT_IDX = 1;
    localparam int ADDR_W       = 2;

    typedef logic [UNIT_LINES-1:0] line_mask_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_PRI_BASE = 2'd0,
        REG_SEC_BASE = 2'd1,
        REG_PRI_EOI  = 2'd2,
        REG_SEC_EOI  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              pri_base_wr;
        logic              sec_base_wr;
        logic              pri_eoi;
        logic              sec_eoi;
        logic [BASE_W-1:0] base;
    } reg_cmd_t;

    // Lowest set index wins: scan downward so the last hit is the smallest.
    function automatic pick_t first_set(line_mask_t m);
        pick_t p;
        p = '0;
        for (int i = UNIT_LINES - 1; i >= 0; i--) begin
            if (m[i]) begin
                p.valid = 1'b1;
                p.idx   = IDX_W'(i);
            end
        end
        return p;
    endfunction

    function automatic line_mask_t idx_mask(logic [IDX_W-1:0] idx);
        return line_mask_t'(1) << idx;
    endfunction

endpackage

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
    import pic_pkg::*;
(
    input  line_mask_t pending,
    input  line_mask_t in_service,
    output pick_t      winner,
    output pick_t      top_service,
    output logic       fire
);
    always_comb begin
        winner      = first_set(pending);
        top_service = first_set(in_service);
        fire        = winner.valid &&
                      (!top_service.valid || (winner.idx < top_service.idx));
    end
endmodule

// File: rtl/pic_reg_decode.sv
module pic_reg_decode
    import pic_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VEC_W-1:0]  wdata,
    output reg_cmd_t          cmd
);
    reg_sel_e sel;

    always_comb begin
        sel             = reg_sel_e'(addr);
        cmd             = '0;
        cmd.base        = wdata[VEC_W-1 -: BASE_W];
        cmd.pri_base_wr = wr && (sel == REG_PRI_BASE);
        cmd.sec_base_wr = wr && (sel == REG_SEC_BASE);
        cmd.pri_eoi     = wr && (sel == REG_PRI_EOI);
        cmd.sec_eoi     = wr && (sel == REG_SEC_EOI);
    end
endmodule

// File: rtl/pic_unit.sv
module pic_unit
    import pic_pkg::*;
#(
    parameter line_mask_t LEVEL_MASK = '0,
    parameter bit         IS_PRIMARY = 1'b0,
    parameter int         LINK_LINE  = CASCADE_LINE
) (
    input  logic              clk,
    input  logic              rst,
    input  line_mask_t        req_in,
    input  logic              base_wr,
    input  logic [BASE_W-1:0] base_in,
    input  logic              eoi,
    input  logic              ack_in,
    output logic              int_out,
    output logic              casc_ack,
    output logic              vec_oe,
    output logic [VEC_W-1:0]  vec_out
);
    line_mask_t        req_q;
    line_mask_t        irr_edge;
    line_mask_t        isr;
    line_mask_t        pending;
    line_mask_t        rise;
    line_mask_t        take_mask;
    line_mask_t        eoi_mask;
    logic [BASE_W-1:0] base_q;
    pick_t             win;
    pick_t             svc;
    logic              fire;
    logic              take;
    logic              to_link;

    // Level lines (the cascade link) follow their input; edge lines latch.
    assign pending = (irr_edge & ~LEVEL_MASK) | (req_in & LEVEL_MASK);
    assign rise    = req_in & ~req_q & ~LEVEL_MASK;

    pic_prio_resolve u_resolve (
        .pending     (pending),
        .in_service  (isr),
        .winner      (win),
        .top_service (svc),
        .fire        (fire)
    );

    assign int_out   = fire;
    assign take      = ack_in && fire;
    assign to_link   = take && IS_PRIMARY && (win.idx == IDX_W'(LINK_LINE));
    assign casc_ack  = to_link;
    assign take_mask = take ? idx_mask(win.idx) : '0;
    assign eoi_mask  = (eoi && svc.valid) ? idx_mask(svc.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= '0;
            irr_edge <= '0;
            isr      <= '0;
            base_q   <= '0;
            vec_oe   <= 1'b0;
            vec_out  <= '0;
        end else begin
            req_q    <= req_in;
            irr_edge <= (irr_edge & ~take_mask) | rise;
            isr      <= (isr & ~eoi_mask) | take_mask;
            if (base_wr) begin
                base_q <= base_in;
            end
            vec_oe <= take && !to_link;
            if (take && !to_link) begin
                vec_out <= {base_q, win.idx};
            end
        end
    end

    // R9: acknowledge with no interrupt raised yields no vector
    a_r9_spurious_ack: assert property (@(posedge clk) disable iff (rst)
        (ack_in && !int_out) |=> !vec_oe);

    // R2: in-service bits are only ever set by an accepted acknowledge
    a_r2_isr_only_on_ack: assert property (@(posedge clk) disable iff (rst)
        !ack_in |=> ((isr & ~$past(isr)) == '0));

    // R8: one end-of-interrupt removes exactly one in-service bit
    a_r8_eoi_clears_one: assert property (@(posedge clk) disable iff (rst)
        (eoi && !ack_in && (isr != '0)) |=>
        ($countones(isr) == $countones($past(isr)) - 1));

    // R5: an accepted acknowledge lands on a line not already in service
    a_r5_no_double_service: assert property (@(posedge clk) disable iff (rst)
        take |-> ((isr & take_mask) == '0));

endmodule

// File: rtl/pic_cascade_ctrl.sv
module pic_cascade_ctrl
    import pic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [EXT_LINES-1:0] irq,
    output logic                 int_out,
    input  logic                 inta,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [VEC_W-1:0]     reg_wdata,
    output logic                 vec_valid,
    output logic [VEC_W-1:0]     vec_data
);
    localparam line_mask_t PRI_LEVEL = idx_mask(IDX_W'(CASCADE_LINE));

    reg_cmd_t         cmd;
    line_mask_t       pri_req;
    line_mask_t       sec_req;
    logic             sec_int;
    logic             sec_ack;
    logic             pri_oe;
    logic             sec_oe;
    logic             pri_link_unused;
    logic             sec_link_unused;
    logic [VEC_W-1:0] pri_vec;
    logic [VEC_W-1:0] sec_vec;

    pic_reg_decode u_decode (
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cmd   (cmd)
    );

    for (genvar i = 0; i < UNIT_LINES; i++) begin : g_map
        if (i == CASCADE_LINE) begin : g_link
            assign pri_req[i] = sec_int;
        end else begin : g_direct
            assign pri_req[i] = irq[i];
        end
        if (i == REDIRECT_IDX) begin : g_legacy
            assign sec_req[i] = irq[UNIT_LINES + i] | irq[LEGACY_LINE];
        end else begin : g_plain
            assign sec_req[i] = irq[UNIT_LINES + i];
        end
    end

    pic_unit #(
        .LEVEL_MASK (PRI_LEVEL),
        .IS_PRIMARY (1'b1),
        .LINK_LINE  (CASCADE_LINE)
    ) u_primary (
        .clk      (clk),
        .rst      (rst),
        .req_in   (pri_req),
        .base_wr  (cmd.pri_base_wr),
        .base_in  (cmd.base),
        .eoi      (cmd.pri_eoi),
        .ack_in   (inta),
        .int_out  (int_out),
        .casc_ack (sec_ack),
        .vec_oe   (pri_oe),
        .vec_out  (pri_vec)
    );

    pic_unit #(
        .LEVEL_MASK ('0),
        .IS_PRIMARY (1'b0),
        .LINK_LINE  (CASCADE_LINE)
    ) u_secondary (
        .clk      (clk),
        .rst      (rst),
        .req_in   (sec_req),
        .base_wr  (cmd.sec_base_wr),
        .base_in  (cmd.base),
        .eoi      (cmd.sec_eoi),
        .ack_in   (sec_ack),
        .int_out  (sec_int),
        .casc_ack (sec_link_unused),
        .vec_oe   (sec_oe),
        .vec_out  (sec_vec)
    );

    assign pri_link_unused = sec_link_unused;
    assign vec_valid = pri_oe | sec_oe;
    assign vec_data  = pri_oe ? pri_vec : (sec_oe ? sec_vec : '0);

    // R6: the two units never drive the vector bus together
    a_r6_single_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pri_oe, sec_oe}));

    // R4: a vector only follows an acknowledge pulse
    a_r4_vec_after_ack: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(inta));

    // R6: the secondary is acknowledged only when it is requesting
    a_r6_link_ack_needs_int: assert property (@(posedge clk) disable iff (rst)
        sec_ack |-> sec_int);

endmodule

// File: tb/test_pic_cascade_ctrl.sv
module test_pic_cascade_ctrl;
    import pic_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [EXT_LINES-1:0] irq = '0;
    logic                 int_out;
    logic                 inta = 1'b0;
    logic                 reg_wr = 1'b0;
    logic [ADDR_W-1:0]    reg_addr = '0;
    logic [VEC_W-1:0]     reg_wdata = '0;
    logic                 vec_valid;
    logic [VEC_W-1:0]     vec_data;

    int   compared   = 0;
    int   mismatched = 0;
    bit   finished   = 1'b0;
    logic [VEC_W-1:0] exp_q[$];
    string            tag_q[$];

    always #5 clk = ~clk;

    pic_cascade_ctrl i_pic_cascade_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq       (irq),
        .int_out   (int_out),
        .inta      (inta),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .vec_valid (vec_valid),
        .vec_data  (vec_data)
    );

    // Monitor: pops the expected vector whenever the design presents one.
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R9: unexpected vector actual=%02h expected=none", vec_data);
            end else begin
                logic [VEC_W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (vec_data !== e) begin
                    mismatched++;
                    $display("FAIL %s: vector actual=%02h expected=%02h", t, vec_data, e);
                end
            end
        end
    end

    task automatic check_bit(input logic act, input logic exp, input string req);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic pulse_irq(input logic [EXT_LINES-1:0] m);
        @(negedge clk); irq = m;
        @(negedge clk); irq = '0;
    endtask

    task automatic ack(input logic [VEC_W-1:0] e, input string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
    endtask

    task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [VEC_W-1:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic eoi_pri(); wr_reg(2'd2, 8'h00); endtask
    task automatic eoi_sec(); wr_reg(2'd3, 8'h00); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_bit(int_out, 1'b0, "R1");
        check_bit(vec_valid, 1'b0, "R1");

        wr_reg(2'd0, 8'h40);
        wr_reg(2'd1, 8'h70);

        // R3/R4 single request
        pulse_irq(16'h0020);
        check_bit(int_out, 1'b1, "R3");
        ack(8'h45, "R4");
        check_bit(int_out, 1'b0, "R5");
        eoi_pri();
        check_bit(int_out, 1'b0, "R8");

        // R3 simultaneous edges 3 and 6
        pulse_irq(16'h0048);
        ack(8'h43, "R3");
        check_bit(int_out, 1'b0, "R5");
        eoi_pri();
        check_bit(int_out, 1'b1, "R8");
        ack(8'h46, "R3");
        eoi_pri();
        check_bit(int_out, 1'b0, "R8");

        // R5 nesting and equal-priority wait
        pulse_irq(16'h0040);
        ack(8'h46, "R5");
        pulse_irq(16'h0040);
        check_bit(int_out, 1'b0, "R5");
        pulse_irq(16'h0002);
        check_bit(int_out, 1'b1, "R5");
        ack(8'h41, "R5");
        check_bit(int_out, 1'b0, "R5");
        eoi_pri();
        check_bit(int_out, 1'b0, "R8");
        pulse_irq(16'h0080);
        check_bit(int_out, 1'b0, "R5");
        eoi_pri();
        check_bit(int_out, 1'b1, "R8");
        ack(8'h46, "R3");
        eoi_pri();
        ack(8'h47, "R3");
        eoi_pri();
        check_bit(int_out, 1'b0, "R8");

        // R6/R10 cascade
        pulse_irq(16'h1000);
        check_bit(int_out, 1'b1, "R6");
        ack(8'h74, "R6");
        check_bit(int_out, 1'b0, "R6");
        pulse_irq(16'h0001);
        check_bit(int_out, 1'b1, "R5");
        ack(8'h40, "R5");
        eoi_pri();
        check_bit(int_out, 1'b0, "R8");
        pulse_irq(16'h0400);
        check_bit(int_out, 1'b0, "R10");
        eoi_sec();
        check_bit(int_out, 1'b0, "R8");
        eoi_pri();
        check_bit(int_out, 1'b1, "R10");
        ack(8'h72, "R10");
        eoi_sec();
        eoi_pri();
        check_bit(int_out, 1'b0, "R8");

        // R7 legacy line
        pulse_irq(16'h0004);
        check_bit(int_out, 1'b1, "R7");
        ack(8'h71, "R7");
        eoi_sec();
        eoi_pri();

        // R6 cascade rank versus primary lines 3 and 1
        pulse_irq(16'h8008);
        ack(8'h77, "R6");
        check_bit(int_out, 1'b0, "R6");
        eoi_sec();
        eoi_pri();
        ack(8'h43, "R6");
        eoi_pri();
        pulse_irq(16'h0102);
        ack(8'h41, "R6");
        check_bit(int_out, 1'b0, "R6");
        eoi_pri();
        ack(8'h70, "R6");
        eoi_sec();
        eoi_pri();
        check_bit(int_out, 1'b0, "R8");

        // R2 held level does not re-request
        @(negedge clk); irq = 16'h0010;
        @(negedge clk);
        check_bit(int_out, 1'b1, "R2");
        ack(8'h44, "R2");
        eoi_pri();
        repeat (3) @(negedge clk);
        check_bit(int_out, 1'b0, "R2");
        irq = '0;
        @(negedge clk); irq = 16'h0010;
        @(negedge clk); irq = '0;
        check_bit(int_out, 1'b1, "R2");
        ack(8'h44, "R2");
        eoi_pri();

        // R9 spurious acknowledge
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
        check_bit(vec_valid, 1'b0, "R9");
        check_bit(int_out, 1'b0, "R9");
        pulse_irq(16'h0020);
        ack(8'h45, "R9");
        eoi_pri();

        // R4 base rewrite, low data bits ignored
        wr_reg(2'd0, 8'hAF);
        pulse_irq(16'h0040);
        ack(8'hAE, "R4");
        @(negedge clk);
        check_bit(vec_valid, 1'b0, "R4");
        eoi_pri();

        repeat (2) @(negedge clk);
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R4: vectors missing actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R1: watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule